// File: doc/BRIEF.md
# Memory-Mapped Lite Serial Port

A small serial port that sits on a simple read/write strobe bus. Software sees four word-aligned registers: a receive-data port, a transmit-data port, a status word and a control word. Characters written to the transmit port wait in a 16-entry queue and go out as fixed 8N1 frames, least significant bit first. Frames arriving on the serial input are sampled at sixteen times the bit rate and land in a 16-entry receive queue, where reads of the receive port take them out in order.

The bit rate comes from an external enable, `baud_tick`, which must pulse once per sixteenth of a bit. The format cannot be changed at run time. Overrun and frame errors are sticky and clear when software reads the status word. The parity-error bit always reads 0, since the format carries no parity. The control word holds two self-clearing queue flush strobes and an interrupt enable. The enable is reflected back in status, so a driver can save it and restore it later. When enabled, a one-cycle interrupt pulse is raised when the receive queue stops being empty or when the transmit queue becomes empty.

Top module: `serlink_ctrl`

## Requirements
- R1: After reset the status word reads 0x04 (only the transmit-empty bit set), `serial_out` is high and `irq` is low.
- R2: `bus_addr[3:2]` selects the register: 0 reads receive data, 1 writes transmit data, 2 reads status, 3 writes control. Only `bus_wdata[7:0]` of a transmit write is queued.
- R3: Each queued character is sent as one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts 16 `baud_tick` pulses, and the line idles high.
- R4: A received character is stored in the receive queue, and reads at offset 0 return the stored characters in arrival order, one per read.
- R5: Each queue holds 16 characters. Status bit 3 flags a full transmit queue and bit 1 a full receive queue. A transmit write to a full queue is dropped and leaves the queued data intact.
- R6: A character that completes while the receive queue is full is discarded and sets the overrun flag (status bit 5).
- R7: A stop bit sampled low sets the frame flag (status bit 6), and the character is still stored. A new frame is only recognised on a high-to-low transition of the input.
- R8: The overrun and frame flags stay set until a status read, which clears them. Status bit 7 always reads 0. Status bit 0 is set when the receive queue holds data, and bit 2 when the transmit queue is empty.
- R9: A low pulse on the serial input that has ended by the middle of the start bit (8 ticks) is ignored and stores nothing.
- R10: Control bit 0 flushes the transmit queue without cutting short the character already being sent. Control bit 1 flushes the receive queue. Both are one-shot strobes.
- R11: Control bit 4 is the interrupt enable. Status bit 4 reads back its current value, and writing 0 to control disables interrupts.
- R12: With interrupts enabled, `irq` pulses for one cycle when the receive queue goes from empty to non-empty, and again when the transmit queue goes from non-empty to empty. With interrupts disabled it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (the receive pop and the flag clear take effect at the clock edge) |
| bus_addr | input | 4 | Byte address inside the 16-byte region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| serial_in | input | 1 | Serial receive line |
| serial_out | output | 1 | Serial transmit line |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The transmitter is exercised with a single character carrying junk in the upper write bits, with a three-character loopback burst, and with an 18-write burst. The single character checks framing and the byte mask. The burst checks ordering. The 18-write burst overfills both queues and so separates a dropped write from a corrupted queue and an overrun from a lost flag. The receiver is also driven directly with a good frame, a frame with a low stop bit and a short glitch, which tell apart correct sampling, frame-error reporting and false-start rejection. The interrupt is counted across transmit-drain and receive-arrival events with the enable both set and clear, and the flush strobes are checked against a character already in flight.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  // Register select from address bits [3:2]
  typedef enum logic [1:0] {
    SEL_RXD  = 2'd0,
    SEL_TXD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // Control word bit positions
  localparam int CT_TXCLR = 0;
  localparam int CT_RXCLR = 1;
  localparam int CT_IE    = 4;

  // Status word, bit 7 down to bit 0
  typedef struct packed {
    logic par_err;
    logic frm_err;
    logic ovr_err;
    logic irq_en;
    logic tx_full;
    logic tx_empty;
    logic rx_full;
    logic rx_avail;
  } stat_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/serlink_fifo.sv
module serlink_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16   // power of two
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic          do_push, do_pop;

  assign level   = wp_q - rp_q;
  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_n = wp_q;
    rp_n = rp_q;
    if (clr) begin
      wp_n = '0;
      rp_n = '0;
    end else begin
      if (do_push) wp_n = wp_q + 1'b1;
      if (do_pop)  rp_n = rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q[AW-1:0]] <= din;
  end
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx #(
  parameter int W   = 8,
  parameter int OSR = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         have_data,
  input  logic [W-1:0] data,
  output logic         take,
  output logic         txd,
  output logic         busy
);
  localparam int TKW = $clog2(OSR);
  localparam int FW  = W + 2;
  localparam int BCW = $clog2(FW);
  localparam logic [TKW-1:0] TK_LAST = TKW'(OSR - 1);

  logic [FW-1:0]  sh_q, sh_n;
  logic [BCW-1:0] bc_q, bc_n;
  logic [TKW-1:0] tk_q, tk_n;
  logic           busy_q, busy_n;

  assign take = !busy_q && have_data;
  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;

  always_comb begin
    sh_n   = sh_q;
    bc_n   = bc_q;
    tk_n   = tk_q;
    busy_n = busy_q;
    if (take) begin
      busy_n = 1'b1;
      sh_n   = {1'b1, data, 1'b0};
      bc_n   = BCW'(FW - 1);
      tk_n   = '0;
    end else if (busy_q && tick) begin
      if (tk_q == TK_LAST) begin
        tk_n = '0;
        if (bc_q == '0) begin
          busy_n = 1'b0;
        end else begin
          sh_n = {1'b1, sh_q[FW-1:1]};
          bc_n = bc_q - 1'b1;
        end
      end else begin
        tk_n = tk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bc_q   <= '0;
      tk_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      bc_q   <= bc_n;
      tk_q   <= tk_n;
      busy_q <= busy_n;
    end
  end
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
#(
  parameter int W   = 8,
  parameter int OSR = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rxd,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         ferr
);
  localparam int TKW = $clog2(OSR);
  localparam int BCW = (W > 1) ? $clog2(W) : 1;
  localparam logic [TKW-1:0] TK_LAST = TKW'(OSR - 1);
  localparam logic [TKW-1:0] TK_MID  = TKW'(OSR / 2 - 1);
  localparam logic [BCW-1:0] BC_LAST = BCW'(W - 1);

  logic [2:0]     sync_q;
  logic           rxs, rxs_d;
  rx_state_e      st_q, st_n;
  logic [TKW-1:0] tk_q, tk_n;
  logic [BCW-1:0] bc_q, bc_n;
  logic [W-1:0]   sh_q, sh_n;

  assign rxs   = sync_q[1];
  assign rxs_d = sync_q[2];
  assign data  = sh_q;

  always_comb begin
    st_n  = st_q;
    tk_n  = tk_q;
    bc_n  = bc_q;
    sh_n  = sh_q;
    valid = 1'b0;
    ferr  = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (rxs_d && !rxs) begin
          st_n = RX_START;
          tk_n = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (tk_q == TK_MID) begin
            tk_n = '0;
            bc_n = '0;
            st_n = rxs ? RX_IDLE : RX_DATA;
          end else begin
            tk_n = tk_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (tk_q == TK_LAST) begin
            tk_n = '0;
            sh_n = {rxs, sh_q[W-1:1]};
            if (bc_q == BC_LAST) st_n = RX_STOP;
            else                 bc_n = bc_q + 1'b1;
          end else begin
            tk_n = tk_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (tk_q == TK_LAST) begin
            valid = 1'b1;
            ferr  = !rxs;
            tk_n  = '0;
            st_n  = RX_IDLE;
          end else begin
            tk_n = tk_q + 1'b1;
          end
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      tk_q   <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      st_q   <= st_n;
      tk_q   <= tk_n;
      bc_q   <= bc_n;
      sh_q   <= sh_n;
    end
  end
endmodule

// File: rtl/serlink_ctrl.sv
module serlink_ctrl
  import serlink_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int OSR        = 16,
  parameter int BUS_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             serial_in,
  output logic             serial_out,
  output logic             irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  reg_sel_e          sel;
  logic              wr_tx, wr_ctl, rd_rx, rd_st;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [CNT_W-1:0]  tx_level, rx_level;
  logic [DATA_W-1:0] tx_head, rx_head, rx_data;
  logic              tx_take, tx_busy, rx_valid, rx_ferr;
  logic              ie_q, ie_n, ovr_q, ovr_n, ferr_q, ferr_n;
  logic              rxne_q, txe_q, irq_q, irq_n;
  stat_t             status;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:DATA_W]};

  assign sel    = reg_sel_e'(bus_addr[3:2]);
  assign wr_tx  = bus_wr && (sel == SEL_TXD);
  assign wr_ctl = bus_wr && (sel == SEL_CTRL);
  assign rd_rx  = bus_rd && (sel == SEL_RXD);
  assign rd_st  = bus_rd && (sel == SEL_STAT);

  serlink_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(wr_ctl && bus_wdata[CT_TXCLR]),
    .push(wr_tx), .din(bus_wdata[DATA_W-1:0]), .pop(tx_take),
    .dout(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level));

  serlink_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(wr_ctl && bus_wdata[CT_RXCLR]),
    .push(rx_valid), .din(rx_data), .pop(rd_rx),
    .dout(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level));

  serlink_tx #(.W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .have_data(!tx_empty),
    .data(tx_head), .take(tx_take), .txd(serial_out), .busy(tx_busy));

  serlink_rx #(.W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(serial_in),
    .valid(rx_valid), .data(rx_data), .ferr(rx_ferr));

  always_comb begin
    status          = '0;
    status.rx_avail = !rx_empty;
    status.rx_full  = rx_full;
    status.tx_empty = tx_empty;
    status.tx_full  = tx_full;
    status.irq_en   = ie_q;
    status.ovr_err  = ovr_q;
    status.frm_err  = ferr_q;
    status.par_err  = 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_st)                   bus_rdata = BUS_W'(status);
    else if (rd_rx && !rx_empty) bus_rdata = BUS_W'(rx_head);
  end

  // Next state of control and flag registers; a new error wins over the clear
  always_comb begin
    ie_n   = wr_ctl ? bus_wdata[CT_IE] : ie_q;
    ovr_n  = (rx_valid && rx_full) || (ovr_q && !rd_st);
    ferr_n = (rx_valid && rx_ferr) || (ferr_q && !rd_st);
    irq_n  = ie_q && ((!rx_empty && !rxne_q) || (tx_empty && !txe_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
      rxne_q <= 1'b0;
      txe_q  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      ie_q   <= ie_n;
      ovr_q  <= ovr_n;
      ferr_q <= ferr_n;
      rxne_q <= !rx_empty;
      txe_q  <= tx_empty;
      irq_q  <= irq_n;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/serlink_chk.sv
module serlink_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          serial_out,
  input logic          tx_busy,
  input logic          ie,
  input logic          ovr,
  input logic          rd_st,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          tx_full,
  input logic          tx_empty
);
  // R5: queues never exceed their depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

  // R5: the full and empty indications never coincide
  p_full_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));

  // R3: line idles high whenever no character is being sent
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> serial_out);

  // R8: overrun stays set until a status read
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rd_st) |=> ovr);

  // R12: a pulse only follows a cycle with interrupts enabled
  p_irq_ie_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie));
endmodule

bind serlink_ctrl serlink_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .serial_out(serial_out),
  .tx_busy(tx_busy), .ie(ie_q), .ovr(ovr_q), .rd_st(rd_st),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_full(tx_full), .tx_empty(tx_empty));

// File: tb/sim_serlink_ctrl.sv
module sim_serlink_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sout, sin, irq;
  logic        loop_en = 1'b0, drv_rx = 1'b1;
  int          n_chk = 0, n_err = 0, irq_cnt = 0;
  bit          done = 1'b0;

  localparam int BITC = 32;  // clocks per bit: 16 ticks, one tick every 2 clocks

  assign sin = loop_en ? sout : drv_rx;

  serlink_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .serial_in(sin), .serial_out(sout), .irq(irq));

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  always @(negedge clk) if (irq === 1'b1) irq_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic get_tx(output logic [7:0] d, output logic stopb);
    int guard = 0;
    while (sout !== 1'b0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    wait_clk(BITC / 2);
    for (int i = 0; i < 8; i++) begin
      wait_clk(BITC);
      d[i] = sout;
    end
    wait_clk(BITC);
    stopb = sout;
  endtask

  task automatic send_char(input logic [7:0] d, input logic stopb);
    drv_rx = 1'b0;
    wait_clk(BITC);
    for (int i = 0; i < 8; i++) begin
      drv_rx = d[i];
      wait_clk(BITC);
    end
    drv_rx = stopb;
    wait_clk(BITC);
    drv_rx = 1'b1;
    wait_clk(2 * BITC);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 serial_out idle", {31'b0, sout}, 32'd1);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
    bus_read(4'h8, v);
    chk("R1 status after reset", v, 32'h04);
  endtask

  task automatic t_ie_mirror;
    logic [31:0] v;
    bus_write(4'hC, 32'h10);
    bus_read(4'h8, v);
    chk("R11 ie readback set", v, 32'h14);
    bus_write(4'hC, 32'h00);
    bus_read(4'h8, v);
    chk("R11 ie readback clear", v, 32'h04);
  endtask

  task automatic t_tx_frame;
    logic [7:0] d; logic s; logic [31:0] v;
    loop_en = 1'b0;
    bus_write(4'h4, 32'hDEADBE5A);
    get_tx(d, s);
    chk("R2 R3 tx low byte only", {24'b0, d}, 32'h5A);
    chk("R3 stop bit high", {31'b0, s}, 32'd1);
    wait_clk(BITC);
    bus_read(4'h8, v);
    chk("R8 status after tx", v, 32'h04);
  endtask

  task automatic t_loopback;
    logic [31:0] v;
    loop_en = 1'b1;
    bus_write(4'h4, 32'h11);
    bus_write(4'h4, 32'h22);
    bus_write(4'h4, 32'h33);
    wait_clk(3 * 10 * BITC + 200);
    bus_read(4'h8, v);
    chk("R4 R8 rx data available", v, 32'h05);
    bus_read(4'h0, v); chk("R4 first char", v, 32'h11);
    bus_read(4'h0, v); chk("R4 second char", v, 32'h22);
    bus_read(4'h0, v); chk("R4 third char", v, 32'h33);
    bus_read(4'h8, v);
    chk("R4 rx drained", v, 32'h04);
    loop_en = 1'b0;
  endtask

  task automatic t_irq;
    logic [31:0] v;
    loop_en = 1'b0;
    bus_write(4'hC, 32'h10);
    irq_cnt = 0;
    bus_write(4'h4, 32'h7E);
    wait_clk(10 * BITC + 100);
    chk("R12 one pulse on tx drain", irq_cnt, 32'd1);
    irq_cnt = 0;
    send_char(8'h3C, 1'b1);
    wait_clk(20);
    chk("R12 one pulse on rx arrival", irq_cnt, 32'd1);
    bus_read(4'h0, v);
    chk("R4 char from line", v, 32'h3C);
    bus_write(4'hC, 32'h00);
    irq_cnt = 0;
    send_char(8'h99, 1'b1);
    wait_clk(20);
    chk("R12 no pulse when disabled", irq_cnt, 32'd0);
    bus_read(4'h0, v);
    chk("R4 char with ie off", v, 32'h99);
  endtask

  task automatic t_full_overrun;
    logic [31:0] v;
    loop_en = 1'b1;
    for (int i = 0; i < 18; i++) bus_write(4'h4, 32'h40 + i);
    bus_read(4'h8, v);
    chk("R5 tx queue full", v, 32'h08);
    wait_clk(17 * 10 * BITC + 1000);
    bus_read(4'h8, v);
    chk("R5 R6 rx full with overrun", v, 32'h27);
    bus_read(4'h8, v);
    chk("R8 overrun cleared by read", v, 32'h07);
    for (int i = 0; i < 16; i++) begin
      bus_read(4'h0, v);
      chk("R5 R6 rx content in order", v, 32'h40 + i);
    end
    bus_read(4'h8, v);
    chk("R5 nothing beyond depth", v, 32'h04);
    loop_en = 1'b0;
  endtask

  task automatic t_tx_flush;
    logic [7:0] d; logic s; logic [31:0] v; int lows;
    loop_en = 1'b0;
    fork
      get_tx(d, s);
      begin
        bus_write(4'h4, 32'h81);
        bus_write(4'h4, 32'h82);
        bus_write(4'h4, 32'h83);
        bus_write(4'hC, 32'h01);
        bus_read(4'h8, v);
        chk("R10 tx flush empties queue", v, 32'h04);
      end
    join
    chk("R10 char in flight completes", {24'b0, d}, 32'h81);
    lows = 0;
    for (int i = 0; i < 15 * BITC; i++) begin
      @(negedge clk);
      if (sout === 1'b0) lows++;
    end
    chk("R10 flushed chars not sent", lows, 32'd0);
    bus_write(4'h4, 32'h55);
    get_tx(d, s);
    chk("R10 queue usable after flush", {24'b0, d}, 32'h55);
    wait_clk(BITC);
  endtask

  task automatic t_rx_flush;
    logic [31:0] v;
    send_char(8'h12, 1'b1);
    send_char(8'h34, 1'b1);
    bus_read(4'h8, v);
    chk("R10 rx holds data", v, 32'h05);
    bus_write(4'hC, 32'h02);
    bus_read(4'h8, v);
    chk("R10 rx flush empties queue", v, 32'h04);
  endtask

  task automatic t_frame;
    logic [31:0] v;
    send_char(8'hC3, 1'b0);
    bus_read(4'h8, v);
    chk("R7 frame flag set", v, 32'h45);
    bus_read(4'h8, v);
    chk("R8 frame flag cleared by read", v, 32'h05);
    bus_read(4'h0, v);
    chk("R7 char kept", v, 32'hC3);
    bus_read(4'h8, v);
    chk("R7 no spurious char", v, 32'h04);
  endtask

  task automatic t_false_start;
    logic [31:0] v;
    drv_rx = 1'b0;
    wait_clk(4);
    drv_rx = 1'b1;
    wait_clk(12 * BITC);
    bus_read(4'h8, v);
    chk("R9 glitch ignored", v, 32'h04);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_ie_mirror();
    t_tx_frame();
    t_loopback();
    t_irq();
    t_full_overrun();
    t_tx_flush();
    t_rx_flush();
    t_frame();
    t_false_start();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule